// File: doc/BRIEF.md
# LCD Panel Power and Configuration Sequencer

This block brings a small LCD panel up and down and keeps its configuration registers in step with the settings held on chip. It drives the panel supply enable, the panel reset line and a write-only SPI link. All traffic is sent as 16-bit words. Delays are counted in ticks of the block clock, and the number of ticks per millisecond is a parameter.

Commands arrive on one valid/ready port. Each command has an operation code and carries its payload. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as a sequence is running, and the source must hold the command steady until it is taken. That back-pressure is the only form of queuing.

A power-up command runs these steps:
- switch the supply on;
- wait the power-up delay;
- release reset;
- write the configuration script.

A power-down command runs a standby script around a reset assertion and then cuts the supply. Runtime commands change the display mode, the vertical mirror setting or the twelve-point gamma curve. They always update the stored value. They produce SPI traffic only while the panel is powered.

Top module: `lcd_panel_seq`

## Requirements
- R1: Each SPI frame holds chip select low for exactly 16 SCLK rising edges and sends one word MSB first. SCLK idles low, and MOSI is stable while SCLK is high. The word holds the register address in bits 15:10, 0 in bit 9, 1 in bit 8 and the data byte in bits 7:0.
- R2: After reset the outputs are as follows: supply off, panel reset asserted (high), chip select high, SCLK low, `busy` low and `cmd_ready` high. The stored mode is 7, mirror is off and the gamma table is 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023.
- R3: Power-up (op 0) turns the supply on and waits at least `PWRUP_MS` ms before releasing panel reset. No frame is sent before reset is released.
- R4: After reset is released, power-up writes these registers in order: register 0x02 = mode OR 0x08, register 0x03 = 0xDF, register 0x20 = 0xF0, register 0x21 = 0xF0, then the flip register, then the 15 gamma registers. That is 20 frames in total.
- R5: The flip register is 0x04. Its value is 0x17 with mirror off and 0x15 with mirror on.
- R6: Gamma registers 0x11, 0x12 and 0x13 each carry bits 9:8 of points 4k to 4k+3, with point 4k in bits 7:6 down to point 4k+3 in bits 1:0. They are followed by the low bytes of points 0 to 11 in registers 0x14 to 0x1F, in that order.
- R7: Power-down (op 1) does the following in order: write register 0x03 = 0xD8, assert panel reset, wait at least `PWRDN_MS` ms, write register 0x03 = 0xD0, switch the supply off.
- R8: A power-up command while powered, or a power-down command while off, produces no frame and no change on the supply or reset lines.
- R9: The mode command (op 2, 3-bit value on `cmd_mode`) writes only register 0x02 = mode OR 0x08 while powered.
- R10: The mirror command (op 3) writes only register 0x04 while powered. The gamma command (op 4, point i on `cmd_gamma` bits 10i+9:10i) rewrites all 15 gamma registers while powered.
- R11: Mode, mirror and gamma commands received while the panel is off send no frame. They are stored and used by the next power-up.
- R12: `busy` is high while a sequence runs and `cmd_ready` is its inverse. A command offered while busy is held and taken after the running sequence ends. Frames are sent only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | 0 power-up, 1 power-down, 2 mode, 3 mirror, 4 gamma |
| cmd_mode | input | 3 | Mode value for op 2 |
| cmd_mirror | input | 1 | Vertical mirror enable for op 3 |
| cmd_gamma | input | 120 | Twelve 10-bit gamma points for op 4, point 0 in the low bits |
| busy | output | 1 | A sequence is running |
| panel_supply_en | output | 1 | Panel supply enable |
| panel_reset | output | 1 | Panel reset, active high |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data out |

## Verification
The bench builds the block with ten ticks per millisecond and an SCLK half period of two clocks. The 160 ms and 50 ms delays keep their real values. A whole power-up script, including the full millisecond countdown, therefore finishes in a few thousand cycles. This lets the bench measure the supply-to-release and reset-to-final-write intervals exactly. It also lets it compare every one of the 20 bring-up frames bit for bit, and cover stored settings, held commands and repeated power requests in one run.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int GAMMA_PTS  = 12;
  localparam int GAMMA_W    = 10;
  localparam int GAMMA_BITS = GAMMA_PTS * GAMMA_W;
  localparam int WORD_W     = 16;
  localparam int PC_W       = 5;

  typedef logic [GAMMA_PTS-1:0][GAMMA_W-1:0] gamma_t;

  typedef enum logic [2:0] {
    OP_PWR_UP = 3'd0,
    OP_PWR_DN = 3'd1,
    OP_MODE   = 3'd2,
    OP_MIRROR = 3'd3,
    OP_GAMMA  = 3'd4
  } cmd_op_e;

  typedef enum logic [2:0] {
    ACT_SUPPLY_ON,
    ACT_SUPPLY_OFF,
    ACT_RST_ON,
    ACT_RST_OFF,
    ACT_DELAY,
    ACT_WRITE
  } act_e;

  typedef struct packed {
    act_e       act;
    logic       long_delay;
    logic [5:0] addr;
    logic [7:0] data;
  } step_t;

  // Script layout: bring-up steps 0..22, shutdown steps 23..27.
  localparam logic [PC_W-1:0] PC_UP_FIRST = 5'd0;
  localparam logic [PC_W-1:0] PC_MODE     = 5'd3;
  localparam logic [PC_W-1:0] PC_FLIP     = 5'd7;
  localparam logic [PC_W-1:0] PC_GAMMA    = 5'd8;
  localparam logic [PC_W-1:0] PC_UP_LAST  = 5'd22;
  localparam logic [PC_W-1:0] PC_DN_FIRST = 5'd23;
  localparam logic [PC_W-1:0] PC_DN_LAST  = 5'd27;

  localparam logic [7:0] EDGE_SEL      = 8'h08;
  localparam logic [7:0] CTRL_RUN      = 8'hDF;
  localparam logic [7:0] CTRL_STBY_PWM = 8'hD8;
  localparam logic [7:0] CTRL_STBY     = 8'hD0;
  localparam logic [7:0] AUX_VAL       = 8'hF0;
  localparam logic [7:0] FLIP_BASE     = 8'h17;
  localparam logic [7:0] FLIP_VBIT     = 8'h02;

  localparam gamma_t GAMMA_RST = {10'd1023, 10'd880, 10'd837, 10'd780,
                                  10'd686,  10'd579, 10'd537, 10'd490,
                                  10'd431,  10'd381, 10'd315, 10'd105};

  function automatic logic [WORD_W-1:0] frame_word(input logic [5:0] addr,
                                                   input logic [7:0] data);
    return {addr, 1'b0, 1'b1, data};
  endfunction

  function automatic step_t step_at(input logic [PC_W-1:0] pc,
                                    input logic [2:0]      mode,
                                    input logic            mirror,
                                    input gamma_t          g);
    step_t s;
    int    idx;
    s   = '{act: ACT_WRITE, long_delay: 1'b0, addr: 6'd0, data: 8'd0};
    idx = 0;
    case (pc) inside
      5'd0:  s.act = ACT_SUPPLY_ON;
      5'd1:  begin s.act = ACT_DELAY; s.long_delay = 1'b1; end
      5'd2:  s.act = ACT_RST_OFF;
      5'd3:  begin s.addr = 6'h02; s.data = {5'd0, mode} | EDGE_SEL; end
      5'd4:  begin s.addr = 6'h03; s.data = CTRL_RUN; end
      5'd5:  begin s.addr = 6'h20; s.data = AUX_VAL; end
      5'd6:  begin s.addr = 6'h21; s.data = AUX_VAL; end
      5'd7:  begin
        s.addr = 6'h04;
        s.data = mirror ? (FLIP_BASE & ~FLIP_VBIT) : FLIP_BASE;
      end
      [5'd8:5'd10]: begin
        idx    = int'(pc) - 8;
        s.addr = 6'h11 + 6'(idx);
        s.data = {g[4*idx][9:8], g[4*idx+1][9:8], g[4*idx+2][9:8], g[4*idx+3][9:8]};
      end
      [5'd11:5'd22]: begin
        idx    = int'(pc) - 11;
        s.addr = 6'h14 + 6'(idx);
        s.data = g[idx][7:0];
      end
      5'd23: begin s.addr = 6'h03; s.data = CTRL_STBY_PWM; end
      5'd24: s.act = ACT_RST_ON;
      5'd25: s.act = ACT_DELAY;
      5'd26: begin s.addr = 6'h03; s.data = CTRL_STBY; end
      default: s.act = ACT_SUPPLY_OFF;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_spi_tx.sv
module lcd_spi_tx #(
  parameter int HALF_DIV = 4,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              done,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_st_e;

  tx_st_e            st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [WORD_W-1:0] sh;
  logic              half_up;

  assign half_up = (cnt == CNT_W'(HALF_DIV - 1));
  assign mosi    = !cs_n && sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: if (start) begin
          sh   <= word;
          cs_n <= 1'b0;
          cnt  <= '0;
          bitn <= '0;
          st   <= TX_SHIFT;
        end
        TX_SHIFT: if (half_up) begin
          cnt  <= '0;
          sclk <= ~sclk;
          if (sclk) begin
            if (bitn == BIT_W'(WORD_W - 1)) begin
              cs_n <= 1'b1;
              st   <= TX_GAP;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[WORD_W-2:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        TX_GAP: if (half_up) begin
          cnt  <= '0;
          done <= 1'b1;
          st   <= TX_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int TICKS_PER_MS = 50000,
  parameter int MS_W         = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms,
  output logic            done
);
  localparam int TICK_W = $clog2(TICKS_PER_MS + 1);

  logic              run;
  logic [TICK_W-1:0] tick;
  logic [MS_W-1:0]   ms_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      tick    <= '0;
      ms_left <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run     <= 1'b1;
        tick    <= '0;
        ms_left <= ms;
      end else if (run) begin
        if (tick == TICK_W'(TICKS_PER_MS - 1)) begin
          tick <= '0;
          if (ms_left <= MS_W'(1)) begin
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            ms_left <= ms_left - 1'b1;
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int MS_W     = 8,
  parameter int LONG_MS  = 160,
  parameter int SHORT_MS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [PC_W-1:0]   first_pc,
  input  logic [PC_W-1:0]   last_pc,
  input  logic [2:0]        mode,
  input  logic              mirror,
  input  gamma_t            gamma,
  input  logic              spi_done,
  input  logic              tmr_done,
  output logic              spi_go,
  output logic [WORD_W-1:0] spi_word,
  output logic              tmr_go,
  output logic [MS_W-1:0]   tmr_ms,
  output logic              busy,
  output logic              supply_en,
  output logic              panel_rst
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_STEP, SQ_SPI, SQ_TMR} sq_e;

  sq_e             st;
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] last;
  step_t           cur;
  logic            pin_step;
  logic            adv;

  assign cur      = step_at(pc, mode, mirror, gamma);
  assign spi_word = frame_word(cur.addr, cur.data);
  assign tmr_ms   = cur.long_delay ? MS_W'(LONG_MS) : MS_W'(SHORT_MS);
  assign busy     = (st != SQ_IDLE);

  always_comb begin
    pin_step = (cur.act == ACT_SUPPLY_ON) || (cur.act == ACT_SUPPLY_OFF) ||
               (cur.act == ACT_RST_ON)    || (cur.act == ACT_RST_OFF);
    adv      = ((st == SQ_STEP) && pin_step) ||
               ((st == SQ_SPI) && spi_done) ||
               ((st == SQ_TMR) && tmr_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      pc        <= '0;
      last      <= '0;
      spi_go    <= 1'b0;
      tmr_go    <= 1'b0;
      supply_en <= 1'b0;
      panel_rst <= 1'b1;
    end else begin
      spi_go <= 1'b0;
      tmr_go <= 1'b0;
      if (st == SQ_IDLE) begin
        if (launch) begin
          pc   <= first_pc;
          last <= last_pc;
          st   <= SQ_STEP;
        end
      end else if (adv) begin
        if (pc == last) begin
          st <= SQ_IDLE;
        end else begin
          pc <= pc + 1'b1;
          st <= SQ_STEP;
        end
      end else if (st == SQ_STEP) begin
        if (cur.act == ACT_WRITE) begin
          spi_go <= 1'b1;
          st     <= SQ_SPI;
        end else begin
          tmr_go <= 1'b1;
          st     <= SQ_TMR;
        end
      end
      if (st == SQ_STEP) begin
        case (cur.act)
          ACT_SUPPLY_ON:  supply_en <= 1'b1;
          ACT_SUPPLY_OFF: supply_en <= 1'b0;
          ACT_RST_ON:     panel_rst <= 1'b1;
          ACT_RST_OFF:    panel_rst <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_panel_seq.sv
module lcd_panel_seq
  import lcd_seq_pkg::*;
#(
  parameter int TICKS_PER_MS  = 50000,
  parameter int SCLK_HALF_DIV = 4,
  parameter int PWRUP_MS      = 160,
  parameter int PWRDN_MS      = 50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [2:0]            cmd_op,
  input  logic [2:0]            cmd_mode,
  input  logic                  cmd_mirror,
  input  logic [GAMMA_BITS-1:0] cmd_gamma,
  output logic                  busy,
  output logic                  panel_supply_en,
  output logic                  panel_reset,
  output logic                  spi_sclk,
  output logic                  spi_cs_n,
  output logic                  spi_mosi
);
  localparam int MAX_MS = (PWRUP_MS > PWRDN_MS) ? PWRUP_MS : PWRDN_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  logic              powered;
  logic [2:0]        mode_q;
  logic              mirror_q;
  gamma_t            gamma_q;
  logic              fire;
  logic              launch;
  logic [PC_W-1:0]   first_pc;
  logic [PC_W-1:0]   last_pc;
  logic              spi_go;
  logic              spi_done;
  logic [WORD_W-1:0] spi_word;
  logic              tmr_go;
  logic              tmr_done;
  logic [MS_W-1:0]   tmr_ms;

  assign cmd_ready = !busy;
  assign fire      = cmd_valid && cmd_ready;

  always_comb begin
    launch   = 1'b0;
    first_pc = PC_UP_FIRST;
    last_pc  = PC_UP_LAST;
    if (fire) begin
      case (cmd_op_e'(cmd_op))
        OP_PWR_UP: launch = !powered;
        OP_PWR_DN: begin
          launch   = powered;
          first_pc = PC_DN_FIRST;
          last_pc  = PC_DN_LAST;
        end
        OP_MODE: begin
          launch   = powered;
          first_pc = PC_MODE;
          last_pc  = PC_MODE;
        end
        OP_MIRROR: begin
          launch   = powered;
          first_pc = PC_FLIP;
          last_pc  = PC_FLIP;
        end
        OP_GAMMA: begin
          launch   = powered;
          first_pc = PC_GAMMA;
        end
        default: launch = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powered  <= 1'b0;
      mode_q   <= 3'd7;
      mirror_q <= 1'b0;
      gamma_q  <= GAMMA_RST;
    end else if (fire) begin
      case (cmd_op_e'(cmd_op))
        OP_PWR_UP: powered  <= 1'b1;
        OP_PWR_DN: powered  <= 1'b0;
        OP_MODE:   mode_q   <= cmd_mode;
        OP_MIRROR: mirror_q <= cmd_mirror;
        OP_GAMMA:  gamma_q  <= gamma_t'(cmd_gamma);
        default: ;
      endcase
    end
  end

  lcd_seq_ctrl #(
    .MS_W    (MS_W),
    .LONG_MS (PWRUP_MS),
    .SHORT_MS(PWRDN_MS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .first_pc (first_pc),
    .last_pc  (last_pc),
    .mode     (mode_q),
    .mirror   (mirror_q),
    .gamma    (gamma_q),
    .spi_done (spi_done),
    .tmr_done (tmr_done),
    .spi_go   (spi_go),
    .spi_word (spi_word),
    .tmr_go   (tmr_go),
    .tmr_ms   (tmr_ms),
    .busy     (busy),
    .supply_en(panel_supply_en),
    .panel_rst(panel_reset)
  );

  lcd_spi_tx #(
    .HALF_DIV(SCLK_HALF_DIV),
    .WORD_W  (WORD_W)
  ) u_spi (
    .clk  (clk),
    .rst_n(rst_n),
    .start(spi_go),
    .word (spi_word),
    .done (spi_done),
    .sclk (spi_sclk),
    .cs_n (spi_cs_n),
    .mosi (spi_mosi)
  );

  lcd_ms_timer #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .MS_W        (MS_W)
  ) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(tmr_go),
    .ms   (tmr_ms),
    .done (tmr_done)
  );
endmodule

// File: rtl/lcd_panel_seq_chk.sv
module lcd_panel_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic panel_supply_en,
  input logic panel_reset,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R1

  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R1

  AST_SUPPLY_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_reset) |-> panel_supply_en); // R3

  AST_RESET_AT_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_supply_en) |-> panel_reset); // R7

  AST_NO_FRAME_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_supply_en |-> spi_cs_n); // R11

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready)); // R12

  AST_FRAME_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy); // R12
endmodule

bind lcd_panel_seq lcd_panel_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_ready      (cmd_ready),
  .busy           (busy),
  .panel_supply_en(panel_supply_en),
  .panel_reset    (panel_reset),
  .spi_sclk       (spi_sclk),
  .spi_cs_n       (spi_cs_n),
  .spi_mosi       (spi_mosi)
);

// File: tb/test_lcd_panel_seq.sv
module test_lcd_panel_seq;
  localparam int TPM   = 10;
  localparam int HALF  = 2;
  localparam int UP_MS = 160;
  localparam int DN_MS = 50;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_op = '0;
  logic [2:0]   cmd_mode = '0;
  logic         cmd_mirror = 1'b0;
  logic [119:0] cmd_gamma = '0;
  logic         busy, panel_supply_en, panel_reset, spi_sclk, spi_cs_n, spi_mosi;

  always #10 clk = ~clk;

  lcd_panel_seq #(
    .TICKS_PER_MS(TPM), .SCLK_HALF_DIV(HALF), .PWRUP_MS(UP_MS), .PWRDN_MS(DN_MS)
  ) i_lcd_panel_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_mirror(cmd_mirror),
    .cmd_gamma(cmd_gamma), .busy(busy), .panel_supply_en(panel_supply_en),
    .panel_reset(panel_reset), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi)
  );

  int checks = 0;
  int errors = 0;

  // Monitor, sampled on the falling clock edge.
  int          cyc = 0;
  int          nw = 0;
  logic [15:0] wv [0:255];
  int          wlen [0:255];
  logic        wrst [0:255];
  int          wstart [0:255];
  logic [15:0] sh = '0;
  int          nbits = 0;
  logic        p_sclk = 1'b0, p_cs = 1'b1, p_rst = 1'b1, p_vcc = 1'b0;
  int          t_vcc_on = 0, t_rel = 0, t_rst_on = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (p_cs && !spi_cs_n) begin
      sh = '0; nbits = 0;
      wrst[nw] <= panel_reset;
      wstart[nw] <= cyc;
    end
    if (!spi_cs_n && spi_sclk && !p_sclk) begin
      sh = {sh[14:0], spi_mosi}; nbits = nbits + 1;
    end
    if (!p_cs && spi_cs_n) begin
      wv[nw] <= sh; wlen[nw] <= nbits; nw <= nw + 1;
    end
    if (!p_vcc && panel_supply_en) t_vcc_on <= cyc;
    if (p_rst && !panel_reset) t_rel <= cyc;
    if (!p_rst && panel_reset) t_rst_on <= cyc;
    p_sclk <= spi_sclk; p_cs <= spi_cs_n; p_rst <= panel_reset; p_vcc <= panel_supply_en;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input int a, input int d);
    return 16'((a << 10) | 256 | d);
  endfunction

  int g_def [12] = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};
  int g_new [12] = '{1023, 0, 512, 256, 768, 1, 1022, 300, 600, 900, 5, 700};
  int g_cur [12];

  // Expected gamma frame k (0..14) from the current model table.
  function automatic logic [15:0] gexp(input int k);
    int v;
    v = 0;
    if (k < 3) begin
      for (int j = 0; j < 4; j++) v = v | (((g_cur[4*k+j] >> 8) & 3) << (6 - 2*j));
      return wd(8'h11 + k, v);
    end
    return wd(8'h14 + k - 3, g_cur[k-3] & 255);
  endfunction

  task automatic send(input logic [2:0] op, input logic [2:0] md, input logic mr, input bit use_new);
    @(negedge clk);
    cmd_op = op; cmd_mode = md; cmd_mirror = mr;
    for (int i = 0; i < 12; i++) cmd_gamma[10*i +: 10] = 10'(use_new ? g_new[i] : g_def[i]);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_powerup(input int base, input int md, input bit mr, input string tag);
    chk(nw - base == 20, "R4 frame count", nw - base, 20);
    chk(wv[base] == wd(2, md | 8), "R4 mode register", wv[base], wd(2, md | 8));
    chk(wv[base+1] == wd(3, 8'hDF), "R4 control register", wv[base+1], wd(3, 8'hDF));
    chk(wv[base+2] == wd(8'h20, 8'hF0), "R4 aux 0x20", wv[base+2], wd(8'h20, 8'hF0));
    chk(wv[base+3] == wd(8'h21, 8'hF0), "R4 aux 0x21", wv[base+3], wd(8'h21, 8'hF0));
    chk(wv[base+4] == wd(4, mr ? 8'h15 : 8'h17), "R5 flip register", wv[base+4], wd(4, mr ? 8'h15 : 8'h17));
    for (int k = 0; k < 15; k++)
      chk(wv[base+5+k] == gexp(k), {"R6 gamma frame ", tag}, wv[base+5+k], gexp(k));
    for (int k = 0; k < 20; k++) begin
      chk(wlen[base+k] == 16, "R1 frame length", wlen[base+k], 16);
      chk(wrst[base+k] == 1'b0, "R3 frame after reset release", wrst[base+k], 0);
    end
    chk(t_rel - t_vcc_on >= UP_MS*TPM && t_rel - t_vcc_on <= UP_MS*TPM + 8,
        "R3 power-up delay", t_rel - t_vcc_on, UP_MS*TPM);
    chk(wstart[base] > t_rel, "R3 first frame after release", wstart[base], t_rel);
    chk(panel_supply_en == 1'b1 && panel_reset == 1'b0, "R3 powered state",
        {panel_supply_en, panel_reset}, 2'b10);
  endtask

  // Runtime vector table: {op, arg, expected frame count, expected last frame}.
  localparam int NV = 5;
  localparam logic [29:0] VEC [NV] = '{
    {3'd3, 3'd1, 8'd1, 16'h1115},
    {3'd2, 3'd2, 8'd1, 16'h090A},
    {3'd3, 3'd0, 8'd1, 16'h1117},
    {3'd2, 3'd7, 8'd1, 16'h090F},
    {3'd0, 3'd0, 8'd0, 16'h0000}
  };

  initial begin
    int base;
    foreach (g_cur[i]) g_cur[i] = g_def[i];
    repeat (3) @(negedge clk);
    // R2: reset state.
    chk(panel_supply_en == 0, "R2 supply off", panel_supply_en, 0);
    chk(panel_reset == 1, "R2 reset asserted", panel_reset, 1);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R2 spi idle", {spi_cs_n, spi_sclk}, 2'b10);
    chk(busy == 0 && cmd_ready == 1, "R2 busy/ready", {busy, cmd_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: mode while off is stored, no traffic.
    base = nw;
    send(3'd2, 3'd5, 1'b0, 1'b0);
    wait_idle();
    chk(nw == base, "R11 no frame while off", nw - base, 0);
    chk(panel_supply_en == 0 && busy == 0, "R11 stays off", {panel_supply_en, busy}, 0);

    // R2/R3/R4/R5/R6: bring-up with default gamma and stored mode 5.
    base = nw;
    send(3'd0, 3'd0, 1'b0, 1'b0);
    wait_idle();
    check_powerup(base, 5, 1'b0, "default");

    // Runtime vector table (R9, R10, R8).
    for (int v = 0; v < NV; v++) begin
      base = nw;
      send(VEC[v][29:27], VEC[v][26:24], VEC[v][24], 1'b0);
      wait_idle();
      chk(nw - base == int'(VEC[v][23:16]), "R9 R10 R8 frame count", nw - base, VEC[v][23:16]);
      if (VEC[v][23:16] != 0)
        chk(wv[nw-1] == VEC[v][15:0], "R9 R10 runtime frame", wv[nw-1], VEC[v][15:0]);
      else
        chk(panel_supply_en == 1 && panel_reset == 0, "R8 repeated power-up", {panel_supply_en, panel_reset}, 2'b10);
    end

    // R10: gamma update while powered.
    foreach (g_cur[i]) g_cur[i] = g_new[i];
    base = nw;
    send(3'd4, 3'd0, 1'b0, 1'b1);
    wait_idle();
    chk(nw - base == 15, "R10 gamma frame count", nw - base, 15);
    for (int k = 0; k < 15; k++)
      chk(wv[base+k] == gexp(k), "R10 gamma frame", wv[base+k], gexp(k));

    // R12: a command offered while busy is held.
    base = nw;
    send(3'd4, 3'd0, 1'b0, 1'b1);
    @(negedge clk);
    cmd_op = 3'd3; cmd_mirror = 1'b1; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1 && cmd_ready == 0, "R12 ready low while busy", {busy, cmd_ready}, 2'b10);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    chk(nw - base == 16, "R12 held command frames", nw - base, 16);
    chk(wv[nw-1] == 16'h1115, "R12 held command last", wv[nw-1], 16'h1115);

    // R7: power-down.
    base = nw;
    send(3'd1, 3'd0, 1'b0, 1'b0);
    wait_idle();
    chk(nw - base == 2, "R7 frame count", nw - base, 2);
    chk(wv[base] == wd(3, 8'hD8) && wrst[base] == 0, "R7 first standby write", wv[base], wd(3, 8'hD8));
    chk(wv[base+1] == wd(3, 8'hD0) && wrst[base+1] == 1, "R7 second standby write", wv[base+1], wd(3, 8'hD0));
    chk(wstart[base+1] - t_rst_on >= DN_MS*TPM, "R7 reset-to-write delay", wstart[base+1] - t_rst_on, DN_MS*TPM);
    chk(panel_supply_en == 0 && panel_reset == 1, "R7 off state", {panel_supply_en, panel_reset}, 2'b01);

    // R8: power-down while off.
    base = nw;
    send(3'd1, 3'd0, 1'b0, 1'b0);
    wait_idle();
    chk(nw == base && panel_supply_en == 0 && panel_reset == 1, "R8 repeated power-down", nw - base, 0);

    // R11: mirror while off, then bring-up uses stored mirror and gamma.
    base = nw;
    send(3'd3, 3'd0, 1'b0, 1'b0);
    wait_idle();
    chk(nw == base, "R11 mirror while off", nw - base, 0);
    base = nw;
    send(3'd0, 3'd0, 1'b0, 1'b0);
    wait_idle();
    check_powerup(base, 7, 1'b0, "stored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule